// File: doc/BRIEF.md
# GPIO interrupt channel router

This block takes a wide set of pad signals and steers any eight of them onto eight interrupt lines for a downstream interrupt controller. Each line has its own input select, trigger style (level or edge), polarity and glitch filter. The controller always receives an active-high level or a one-clock rising pulse. This holds even when the pad signals a low level or a falling edge, because each line can invert its input before detection.

Each pad passes through a two-flop synchronizer. A per-channel multiplexer then picks one synchronized pad. A select value beyond the populated pads picks a constant zero. The picked bit is XORed with the channel's low-polarity bit and then enters a filter state machine. The filter has three states: `FLT_BYPASS` for a filter value of 0, `FLT_STABLE` while the input matches the held level, and `FLT_QUALIFY` while a differing input is being counted.

The filter transitions are as follows:
- Any state goes to `FLT_BYPASS` when the filter value is written to 0.
- `FLT_BYPASS` goes to `FLT_STABLE` when the filter value becomes non-zero.
- `FLT_STABLE` goes to `FLT_QUALIFY` on the first sample that differs from the held level.
- `FLT_QUALIFY` goes back to `FLT_STABLE` when the input returns to the held level, which rejects the glitch.
- `FLT_QUALIFY` also goes to `FLT_STABLE`, taking the new level, once 2^k consecutive differing samples have been seen.
- A change to a channel's select or trigger settings forces a reload into `FLT_STABLE` or `FLT_BYPASS`, whichever applies.

Software configures the block through a four-word register port.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, all four configuration words read as zero and all eight interrupt outputs are low.
- R2: The register port holds four 32-bit words, selected by a 2-bit address and written on a clock edge while the write strobe is high. Read data is combinational from the address and returns the stored bits; every unused bit reads zero.
  - Word 0 holds the edge-mode bit of channel n at bit n and the low-polarity bit at bit 16+n.
  - Word 1 holds the selects of channels 0-3 and word 2 holds the selects of channels 4-7.
  - Word 3 holds a 4-bit filter value for channel n at bits 4n+3:4n.
- R3: Channel n's 8-bit select sits at bits 8*(n mod 4)+7 : 8*(n mod 4) of its select word and names a pad index. An index at or above the number of populated pads yields a constant 0 before polarity is applied.
- R4: Pad inputs are synchronized by two flops. With the filter value at 0, a level-mode output reflects a pad change after exactly two rising clock edges.
- R5: When a channel's low-polarity bit is 1, the selected pad value is inverted before filtering and detection.
- R6: In level mode (edge bit 0), the output equals the filtered, polarity-corrected signal.
- R7: In edge mode (edge bit 1), the output is high for exactly one cycle on each 0-to-1 transition of the filtered, polarity-corrected signal. It never pulses on a 1-to-0 transition.
- R8: With filter value k > 0, a new level is accepted only after 2^k consecutive clock samples that differ from the held level. A run of 2^k - 1 differing samples is rejected. With k = 0 the filter is bypassed.
- R9: A write that changes a channel's select or its mode or polarity bits does not by itself produce an edge-mode pulse on that channel.
- R10: Channels are independent: stimulus on a pad selected only by channel n never changes any other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NUM_PADS | Asynchronous pad signals |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| irq_o | output | 8 | Active-high interrupt lines, one per channel |

## Verification
The embedded properties check the following on every cycle:
- An edge-mode pulse never lasts two cycles.
- A settled filter holds its level.
- A configuration change never coincides with an edge-mode pulse.
- An unfiltered level channel tracks its synchronized, polarity-corrected pad.
- An unpopulated select keeps the output low.
- Spare bits of the mode word read zero.

The exact latency in clock edges, the rejection of a glitch one sample too short, and the absence of pulses on falling transitions can only be shown by the bench's sweeps. The same holds for independence between channels and for register readback. The sweeps cover every channel, two pads per channel, all four trigger and polarity combinations, and filter values 0 to 3.

// File: rtl/gpio_irq_router_pkg.sv
package gpio_irq_router_pkg;

    localparam int unsigned CH_COUNT     = 8;
    localparam int unsigned SEL_W        = 8;
    localparam int unsigned FLT_W        = 4;
    localparam int unsigned DATA_W       = 32;
    localparam int unsigned ADDR_W       = 2;
    localparam int unsigned LOW_BASE     = 16;
    localparam int unsigned SEL_PER_WORD = DATA_W / SEL_W;

    localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SEL_LO = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SEL_HI = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_FILT   = 2'd3;

    typedef enum logic [1:0] {
        FLT_BYPASS  = 2'd0,
        FLT_STABLE  = 2'd1,
        FLT_QUALIFY = 2'd2
    } flt_state_e;

    typedef struct packed {
        logic             trig_edge;
        logic             act_low;
        logic [SEL_W-1:0] sel;
        logic [FLT_W-1:0] flt;
    } chan_cfg_t;

endpackage

// File: rtl/irq_pad_sync.sv
module irq_pad_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import gpio_irq_router_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output chan_cfg_t [CH_COUNT-1:0] cfg_o,
    output logic [CH_COUNT-1:0]      chg_o
);

    for (genvar n = 0; n < CH_COUNT; n++) begin : g_ch
        localparam int unsigned SLOT = n % SEL_PER_WORD;
        localparam logic [ADDR_W-1:0] SEL_ADDR =
            (n < SEL_PER_WORD) ? ADDR_SEL_LO : ADDR_SEL_HI;

        chan_cfg_t cfg_r;
        logic      chg_r;
        logic      mode_hit, sel_hit, filt_hit, mode_diff, sel_diff;

        always_comb begin
            mode_hit  = wr_en && (addr == ADDR_MODE);
            sel_hit   = wr_en && (addr == SEL_ADDR);
            filt_hit  = wr_en && (addr == ADDR_FILT);
            mode_diff = (wdata[n] != cfg_r.trig_edge) ||
                        (wdata[LOW_BASE+n] != cfg_r.act_low);
            sel_diff  = (wdata[SLOT*SEL_W +: SEL_W] != cfg_r.sel);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_r <= '0;
                chg_r <= 1'b0;
            end else begin
                chg_r <= (mode_hit && mode_diff) || (sel_hit && sel_diff);
                if (mode_hit) begin
                    cfg_r.trig_edge <= wdata[n];
                    cfg_r.act_low   <= wdata[LOW_BASE+n];
                end
                if (sel_hit) begin
                    cfg_r.sel <= wdata[SLOT*SEL_W +: SEL_W];
                end
                if (filt_hit) begin
                    cfg_r.flt <= wdata[n*FLT_W +: FLT_W];
                end
            end
        end

        assign cfg_o[n] = cfg_r;
        assign chg_o[n] = chg_r;
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < CH_COUNT; n++) begin
            if (addr == ADDR_MODE) begin
                rdata[n]          = cfg_o[n].trig_edge;
                rdata[LOW_BASE+n] = cfg_o[n].act_low;
            end
            if (addr == ((n < SEL_PER_WORD) ? ADDR_SEL_LO : ADDR_SEL_HI)) begin
                rdata[(n % SEL_PER_WORD)*SEL_W +: SEL_W] = cfg_o[n].sel;
            end
            if (addr == ADDR_FILT) begin
                rdata[n*FLT_W +: FLT_W] = cfg_o[n].flt;
            end
        end
    end

    // R2: spare bits of the mode word never read back as set
    a_r2_mode_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_MODE) |-> (rdata[15:8] == 8'h00 && rdata[31:24] == 8'h00));

endmodule

// File: rtl/irq_chan_cond.sv
module irq_chan_cond
    import gpio_irq_router_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      raw_i,
    input  chan_cfg_t cfg_i,
    input  logic      chg_i,
    output logic      irq_o
);

    localparam int unsigned CNT_W = (1 << FLT_W) - 1;

    flt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, limit;
    logic             lvl_q, lvl_d, prev_q;
    logic             pol, bypass, filtered;

    assign pol    = raw_i ^ cfg_i.act_low;
    assign bypass = (cfg_i.flt == '0);
    assign limit  = (CNT_W'(1) << cfg_i.flt) - CNT_W'(1);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FLT_BYPASS;
            cnt_q  <= '0;
            lvl_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            lvl_q  <= lvl_d;
            prev_q <= chg_i ? pol : filtered;
        end
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lvl_d = lvl_q;
        if (chg_i) begin
            st_d  = bypass ? FLT_BYPASS : FLT_STABLE;
            cnt_d = '0;
            lvl_d = pol;
        end else begin
            unique case (st_q)
                FLT_BYPASS: begin
                    lvl_d = pol;
                    cnt_d = '0;
                    if (!bypass) st_d = FLT_STABLE;
                end
                FLT_STABLE: begin
                    if (bypass) begin
                        st_d  = FLT_BYPASS;
                        lvl_d = pol;
                    end else if (pol != lvl_q) begin
                        st_d  = FLT_QUALIFY;
                        cnt_d = CNT_W'(1);
                    end
                end
                FLT_QUALIFY: begin
                    if (bypass) begin
                        st_d  = FLT_BYPASS;
                        lvl_d = pol;
                        cnt_d = '0;
                    end else if (pol == lvl_q) begin
                        st_d  = FLT_STABLE;
                        cnt_d = '0;
                    end else if (cnt_q >= limit) begin
                        st_d  = FLT_STABLE;
                        lvl_d = pol;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    st_d  = FLT_BYPASS;
                    cnt_d = '0;
                    lvl_d = pol;
                end
            endcase
        end
    end

    // output process
    always_comb begin
        filtered = bypass ? pol : lvl_q;
        if (cfg_i.trig_edge) begin
            irq_o = filtered && !prev_q && !chg_i;
        end else begin
            irq_o = filtered;
        end
    end

    // R7: an edge-mode pulse lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.trig_edge && irq_o) |=> (!cfg_i.trig_edge || !irq_o));

    // R8: a settled filter keeps its level across the next edge
    a_r8_settled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLT_STABLE && !chg_i && pol == lvl_q && !bypass) |=> $stable(lvl_q));

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_router_pkg::*;
#(
    parameter int unsigned NUM_PADS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_i,
    input  logic                cfg_wr,
    input  logic [1:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic [7:0]          irq_o
);

    localparam int unsigned SEL_SPAN = 1 << SEL_W;

    logic [NUM_PADS-1:0]        pad_s;
    logic [SEL_SPAN-1:0]        pad_ext;
    chan_cfg_t [CH_COUNT-1:0]   cfg;
    logic [CH_COUNT-1:0]        chg;
    logic [CH_COUNT-1:0]        raw;

    irq_pad_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_i),
        .sync_o  (pad_s)
    );

    // unpopulated select indices see the zero extension
    assign pad_ext = SEL_SPAN'(pad_s);

    irq_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg_o (cfg),
        .chg_o (chg)
    );

    for (genvar n = 0; n < CH_COUNT; n++) begin : g_chan
        assign raw[n] = pad_ext[cfg[n].sel];

        irq_chan_cond u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw[n]),
            .cfg_i (cfg[n]),
            .chg_i (chg[n]),
            .irq_o (irq_o[n])
        );

        // R9: a configuration change never coincides with an edge pulse
        a_r9_quiet_on_change: assert property (@(posedge clk) disable iff (!rst_n)
            (chg[n] && cfg[n].trig_edge) |-> !irq_o[n]);

        // R6: unfiltered level channel tracks its corrected pad
        a_r6_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg[n].trig_edge && cfg[n].flt == '0) |-> (irq_o[n] == (raw[n] ^ cfg[n].act_low)));

        // R3: an unpopulated, non-inverted level channel stays low
        a_r3_unpopulated_low: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg[n].sel) >= NUM_PADS && !cfg[n].act_low && !cfg[n].trig_edge &&
             cfg[n].flt == '0) |-> !irq_o[n]);
    end

endmodule

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pads = '0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [7:0]    irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    gpio_irq_router #(.NUM_PADS(NP)) u_gpio_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_i     (pads),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_o     (irq)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        step();
        cfg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic run_vec(input int ch, input int pad, input bit low, input bit edg, input int k);
        logic [31:0] mode, slo, shi, flt;
        int lat;
        lat  = 2 + ((k == 0) ? 0 : (1 << k));
        pads = low ? (NP'(1) << pad) : '0;
        repeat (3) step();
        mode = (32'(edg) << ch) | (32'(low) << (16 + ch));
        slo  = 32'hFFFF_FFFF;
        shi  = 32'hFFFF_FFFF;
        if (ch < 4) slo[ch*8 +: 8] = 8'(pad);
        else        shi[(ch-4)*8 +: 8] = 8'(pad);
        flt  = 32'(k) << (4 * ch);
        wr(2'd3, flt);
        wr(2'd1, slo);
        wr(2'd2, shi);
        wr(2'd0, mode);
        repeat ((1 << k) + 6) step();
        check("R10 idle before stimulus", 32'(irq), 32'h0);
        // activate (pad goes to its active level, R5 inverts for low polarity)
        pads ^= (NP'(1) << pad);
        for (int c = 1; c <= lat + 2; c++) begin
            step();
            if (edg) check("R7 R4 R5 R8 rising pulse", 32'(irq), (c == lat) ? (32'(1) << ch) : 32'h0);
            else     check("R6 R4 R5 R8 level assert", 32'(irq), (c >= lat) ? (32'(1) << ch) : 32'h0);
        end
        // release
        pads ^= (NP'(1) << pad);
        for (int c = 1; c <= lat + 2; c++) begin
            step();
            if (edg) check("R7 no pulse on release", 32'(irq), 32'h0);
            else     check("R6 R8 level release", 32'(irq), (c < lat) ? (32'(1) << ch) : 32'h0);
        end
        // glitch one sample too short
        if (k > 0) begin
            pads ^= (NP'(1) << pad);
            for (int c = 1; c < (1 << k); c++) begin
                step();
                check("R8 glitch rejected", 32'(irq), 32'h0);
            end
            pads ^= (NP'(1) << pad);
            for (int c = 1; c <= (1 << k) + 4; c++) begin
                step();
                check("R8 glitch rejected", 32'(irq), 32'h0);
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reset word", d, 32'h0);
        end
        check("R1 reset outputs", 32'(irq), 32'h0);

        // R2: readback and spare bits
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R2 mode spare bits", d, 32'h00FF_00FF);
        wr(2'd0, 32'h5A3C_C35A);
        rd(2'd0, d); check("R2 mode readback", d, 32'h003C_005A);
        wr(2'd1, 32'h1234_5678);
        rd(2'd1, d); check("R2 select low word", d, 32'h1234_5678);
        wr(2'd2, 32'h9ABC_DEF0);
        rd(2'd2, d); check("R2 select high word", d, 32'h9ABC_DEF0);
        wr(2'd3, 32'hA5A5_0F0F);
        rd(2'd3, d); check("R2 filter word", d, 32'hA5A5_0F0F);
        rd(2'd1, d); check("R2 words independent", d, 32'h1234_5678);
        wr(2'd0, 32'h0); wr(2'd3, 32'h0);

        // R3: unpopulated selects on channel 2
        wr(2'd1, 32'hFFC8_10FF);
        pads = '1;
        repeat (4) step();
        check("R3 unpopulated select low", 32'(irq), 32'h0);
        wr(2'd0, 32'h0004_0000);
        repeat (3) step();
        check("R3 unpopulated select inverted", 32'(irq), 32'h04);
        pads = '0;
        repeat (3) step();
        check("R3 unpopulated ignores pads", 32'(irq), 32'h04);
        wr(2'd0, 32'h0);

        // R10: two channels on one pad, opposite polarity
        wr(2'd1, 32'hFFFF_0404);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0002_0000);
        repeat (3) step();
        check("R10 shared pad idle", 32'(irq), 32'h02);
        pads[4] = 1'b1;
        step();
        check("R4 one edge not enough", 32'(irq), 32'h02);
        step();
        check("R10 shared pad active", 32'(irq), 32'h01);
        pads[4] = 1'b0;
        wr(2'd0, 32'h0);

        // R9: select and mode changes on an edge channel, with and without filter
        for (int kk = 0; kk <= 2; kk += 2) begin
            wr(2'd3, 32'(kk) << 20);
            pads = 16'h0080;
            wr(2'd2, 32'hFFFF_03FF);
            wr(2'd0, 32'h0000_0020);
            repeat (8) step();
            check("R9 settled", 32'(irq), 32'h0);
            wr(2'd2, 32'hFFFF_07FF);
            for (int c = 0; c < 8; c++) begin
                check("R9 select change no pulse", 32'(irq), 32'h0);
                step();
            end
            wr(2'd0, 32'h0020_0020);
            for (int c = 0; c < 8; c++) begin
                check("R9 polarity change no pulse", 32'(irq), 32'h0);
                step();
            end
            wr(2'd0, 32'h0000_0020);
            for (int c = 0; c < 8; c++) begin
                check("R9 polarity restore no pulse", 32'(irq), 32'h0);
                step();
            end
            pads = '0;
            wr(2'd0, 32'h0);
            repeat (6) step();
        end

        // Sweep: every channel, two pads, all modes, filter 0..3
        for (int ch = 0; ch < 8; ch++) begin
            for (int pi = 0; pi < 2; pi++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int k = 0; k < 4; k++) begin
                        run_vec(ch, (pi == 0) ? ch : (NP - 1 - ch), m[0], m[1], k);
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule